// File: doc/BRIEF.md
# Dual Plane Page Write Controller

This block fronts a byte-wide memory that is divided into two equal planes, selected by the most significant address bit. A host writes a page of one up to `PAGE_BYTES` bytes. All of them share the address bits above the page offset. Each accepted byte reopens a byte-load window of `LOAD_CYC` clocks. When the window closes with no new byte, the block runs a programming interval of `PROG_CYC` clocks. At the end of that interval it commits the whole page to the array in one step.

While a page is being loaded or programmed, the plane that holds it is busy. A read of the busy plane is a status poll: bit 6 of the returned byte alternates on every such read and all other bits read zero. A read of the other plane returns true array contents at all times, so code can keep running from one plane while the other is updated. A write-control input held high while a page is loading discards the page. The same input also blocks the start of a new page.

The array is a behavioural RAM that is cleared by reset. With the default `ADDR_W` of 11, each plane holds 1 KiB. Setting `ADDR_W` to 13 gives two 4 KiB planes. Real-time limits map onto clock counts: `LOAD_CYC` stands for the 100 µs byte-load limit and `PROG_CYC` for the 5 ms write cycle.

Top module: `dual_plane_page_writer`

## Requirements
- R1: After reset the block is idle, `rdata` is 0 and every array byte reads as 0.
- R2: When idle, a read (`rd_en` high for one clock) returns the addressed array byte on `rdata` at the next clock edge, and `rdata` holds that value until the next read.
- R3: In the idle state, a write with `wc` low starts a page. It captures address bits `[ADDR_W-1:5]` as the page tag. Bytes with the same tag are buffered by their offset `addr[4:0]`, and a later byte at the same offset replaces the earlier one. After the last accepted byte, `LOAD_CYC` quiet clocks pass before programming starts. Programming lasts `PROG_CYC` clocks, and at its end every buffered byte is written to the array.
- R4: Each accepted byte restarts the byte-load window, so bytes spaced less than `LOAD_CYC` clocks apart all join one page.
- R5: While loading, a byte whose tag differs from the page tag is discarded. It does not restart the window.
- R6: While a page is loading or programming, a read whose top address bit equals the page's plane returns `{1'b0, t, 6'b0}`. The bit `t` is 0 on the first such read after the page started and inverts on each later one.
- R7: While a page is loading or programming, a read of the other plane returns true array data.
- R8: `wc` high on any clock while loading aborts the page, and nothing is programmed. A write issued with `wc` high while idle does not start a page.
- R9: Writes that arrive while programming is in progress are ignored.
- R10: Once the page has been committed, the toggling stops and reads of that plane return the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock write request for `addr`/`wdata` |
| wc | input | 1 | Write control: high blocks new pages and aborts a loading page |
| rd_en | input | 1 | One-clock read request for `addr` |
| addr | input | ADDR_W | Byte address; the top bit selects the plane |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status, registered, valid the clock after `rd_en` |

## Verification
A wrong timer or state shows up first as a read of the busy plane that returns data when status was due, or status when data was due. The bench samples this at the exact clock where the page commits and on the clock that follows, so an off-by-one in the window or programming counter shows within one poll. A toggle bit that does not restart per page, or does not flip per poll, corrupts bit 6 on the first or second poll. A buffer or tag fault appears as wrong bytes on the read-back that follows each commit, and a plane-select fault appears at once as status bytes on reads of the idle plane.

// File: rtl/dual_plane_page_writer.sv
module dual_plane_page_writer #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int LOAD_CYC   = 16,
  parameter int PROG_CYC   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wc,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMAX  = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                   state;
  logic [7:0]            mem    [DEPTH];
  logic [7:0]            page_d [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [TAG_W-1:0]      tag;
  logic [CNT_W-1:0]      cnt;
  logic                  tog;

  wire [TAG_W-1:0] a_tag = addr[ADDR_W-1:OFS_W];
  wire [OFS_W-1:0] a_ofs = addr[OFS_W-1:0];
  wire             poll  = rd_en && (state != S_IDLE) && (addr[ADDR_W-1] == tag[TAG_W-1]);
  wire             wr_ok = wr_en && !wc &&
                           (state == S_IDLE || (state == S_LOAD && a_tag == tag));
  wire             load_end = (cnt == CNT_W'(LOAD_CYC - 1));
  wire             prog_end = (cnt == CNT_W'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mask  <= '0;
      tag   <= '0;
      cnt   <= '0;
      tog   <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) page_d[i] <= '0;
    end else begin
      if (poll) begin
        rdata <= {1'b0, tog, 6'b0};
        tog   <= ~tog;
      end else if (rd_en) begin
        rdata <= mem[addr];
      end
      case (state)
        S_IDLE: if (wr_ok) begin
          state         <= S_LOAD;
          tag           <= a_tag;
          mask          <= PAGE_BYTES'(1) << a_ofs;
          page_d[a_ofs] <= wdata;
          cnt           <= '0;
          tog           <= 1'b0;
        end
        S_LOAD: begin
          if (wc) begin
            state <= S_IDLE;
            mask  <= '0;
          end else if (wr_ok) begin
            page_d[a_ofs] <= wdata;
            mask          <= mask | (PAGE_BYTES'(1) << a_ofs);
            cnt           <= '0;
          end else if (load_end) begin
            state <= S_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROG: begin
          if (prog_end) begin
            for (int i = 0; i < PAGE_BYTES; i++)
              if (mask[i]) mem[{tag, OFS_W'(i)}] <= page_d[i];
            mask  <= '0;
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (mask == '0));

  assert_window_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && !load_end && !wc) |=> (state == S_LOAD));

  assert_tag_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(tag));

  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll |=> (tog != $past(tog)));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && wc) |=> (state == S_IDLE && mask == '0));

  assert_prog_ignores_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && !prog_end) |=> (state == S_PROG && $stable(mask) && $stable(tag)));
endmodule

// File: tb/dual_plane_page_writer_tb.sv
module dual_plane_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int L  = 16;
  localparam int P  = 64;
  localparam int PB = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wc = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] got;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_plane_page_writer #(.ADDR_W(AW), .PAGE_BYTES(32), .LOAD_CYC(L), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wc(wc), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status(bit t);
    return {1'b0, t, 6'b0};
  endfunction

  task automatic do_wr(logic [AW-1:0] a, logic [7:0] d, bit w);
    wr_en = 1'b1; addr = a; wdata = d; wc = w;
    @(negedge clk);
    wr_en = 1'b0; wc = 1'b0;
  endtask

  task automatic do_rd(logic [AW-1:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    check("R1 reset rdata", rdata, 8'h00);
    do_rd(11'h123); check("R1 array cleared", got, 8'h00);

    // page in plane 0, three bytes, then polls
    do_wr(11'h040, 8'h11, 0);
    do_wr(11'h05F, 8'h22, 0);
    do_wr(11'h041, 8'h33, 0);               // edge E
    do_rd(11'h400); check("R7 other plane during load", got, 8'h00);
    do_rd(11'h000); check("R6 first poll", got, status(0));
    do_rd(11'h3FF); check("R6 second poll", got, status(1));
    idle(L + P - 4);
    do_rd(11'h000); check("R6 poll at commit edge", got, status(0));
    do_rd(11'h040); check("R10 data after commit", got, 8'h11);
    do_rd(11'h05F); check("R3 last offset", got, 8'h22);
    do_rd(11'h041); check("R3 third byte", got, 8'h33);
    model[11'h040] = 8'h11; model[11'h05F] = 8'h22; model[11'h041] = 8'h33;
    do_rd(11'h040); check("R2 idle read", got, 8'h11);
    idle(2); check("R2 rdata held", rdata, 8'h11);

    // window restart, mismatched tag, writes during programming
    do_wr(11'h480, 8'hAA, 0);
    idle(L - 2);
    do_wr(11'h481, 8'hBB, 0);               // edge E1, window restarts (R4)
    do_wr(11'h4A0, 8'hCC, 0);               // other tag, discarded (R5)
    do_rd(11'h400); check("R6 poll during load", got, status(0));
    do_rd(11'h040); check("R7 plane0 while plane1 busy", got, 8'h11);
    idle(L + 1);
    do_wr(11'h482, 8'hDD, 0);               // during programming (R9)
    idle(P - 6);
    do_rd(11'h480); check("R4 still busy at restarted commit edge", got, status(1));
    do_rd(11'h480); check("R4 first byte committed", got, 8'hAA);
    do_rd(11'h481); check("R4 late byte joined page", got, 8'hBB);
    do_rd(11'h4A0); check("R5 mismatched tag discarded", got, 8'h00);
    do_rd(11'h482); check("R9 write during programming ignored", got, 8'h00);
    model[11'h480] = 8'hAA; model[11'h481] = 8'hBB;

    // abort while loading
    do_wr(11'h100, 8'h55, 0);
    wc = 1'b1; idle(1); wc = 1'b0;
    do_rd(11'h100); check("R8 aborted page releases plane", got, 8'h00);
    idle(L + P + 4);
    do_rd(11'h100); check("R8 aborted page not programmed", got, 8'h00);
    do_wr(11'h040, 8'h99, 1);
    do_rd(11'h040); check("R8 write with wc high starts no page", got, 8'h11);
    idle(L + P + 4);
    do_rd(11'h040); check("R8 blocked write not programmed", got, 8'h11);

    // rewriting an offset within one page
    do_wr(11'h2E3, 8'h01, 0);
    do_wr(11'h2E3, 8'h02, 0);
    idle(L + P + 2);
    do_rd(11'h2E3); check("R3 later byte replaces earlier", got, 8'h02);
    model[11'h2E3] = 8'h02;

    // constrained random pages
    void'($urandom(32'h5EED_0042));
    for (int pg = 0; pg < 24; pg++) begin
      logic [AW-1:0] base;
      logic [AW-1:0] wa [8];
      logic [7:0]    wd [8];
      int nb;
      base = AW'($urandom_range(0, (1 << AW) - 1)) & ~AW'(31);
      nb = $urandom_range(1, 8);
      for (int k = 0; k < nb; k++) begin
        wa[k] = base | AW'($urandom_range(0, 31));
        wd[k] = 8'($urandom);
        do_wr(wa[k], wd[k], 0);
        if ($urandom_range(0, 1) == 1) begin
          logic [AW-1:0] ra;
          ra = AW'($urandom_range(0, PB - 1)) | (base[AW-1] ? AW'(0) : AW'(PB));
          do_rd(ra); check("R7 random other-plane read", got, model[ra]);
        end
      end
      idle(L + P + 2);
      for (int k = 0; k < nb; k++) model[wa[k]] = wd[k];
      for (int k = 0; k < nb; k++) begin
        do_rd(wa[k]); check("R3 random page read-back", got, model[wa[k]]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule